// File: doc/BRIEF.md
# Segment Base-Limit Translator

This block takes one memory reference at a time, given as an offset inside a segment, and turns it into a flat linear address. Alongside the offset it receives the descriptor fields the reference relies on: the segment start address, a 20-bit size field, a scaling flag and the privilege ring the segment demands. It also receives the code selector of the running context. The linear address is the start address plus the offset, wrapping modulo 2^32. Two checks run on every reference. A size check rejects offsets at or beyond the segment end. A privilege check rejects callers whose ring is less privileged than the segment allows.

References enter on a valid/ready stream and leave one registered stage later on a second valid/ready stream. The input side accepts a beat when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. If the consumer holds `out_ready` low, the output beat stays frozen and new input is refused. A rejected reference still produces an output beat. That beat has `flt` high and a zero address, so the fault shows as one pulse per faulting transfer.

Top module: `seg_xlate`

## Requirements
- R1: For a legal reference, the output beat carries `lin_addr` = (`in_base` + `in_off`) mod 2^32. It appears in the cycle after the input beat is accepted.
- R2: With `in_gran` = 0, a reference is a limit fault exactly when `in_off` >= `in_limit`. A zero limit therefore faults at offset 0.
- R3: With `in_gran` = 1, a reference is a limit fault exactly when `in_off` >= `in_limit` * 4096, which is the limit shifted left by 12 bits.
- R4: `cpl` on an output beat equals bits [1:0] of that beat's `in_sel`. Ring 0 is the most privileged level and ring 3 the least.
- R5: A reference is a privilege fault exactly when the ring in `in_sel[1:0]` is numerically greater than `in_dpl`. Equal rings pass.
- R6: Whenever `flt` is high, `lin_addr` is zero.
- R7: While `out_valid` is high and `out_ready` is low, `lin_addr`, `flt` and `cpl` hold steady, `in_ready` is low, and no input beat is taken.
- R8: After reset, `out_valid` and `flt` are low, `lin_addr` is zero and `in_ready` is high.
- R9: `flt` is high only together with `out_valid`. Once a faulting beat is drained and no new beat follows, `flt` returns low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_off | input | 32 | Offset within the segment |
| in_base | input | 32 | Segment start address |
| in_limit | input | 20 | Segment size field |
| in_gran | input | 1 | 1 scales the size field by 4096 |
| in_sel | input | 16 | Code selector, ring in bits [1:0] |
| in_dpl | input | 2 | Ring the segment requires |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| lin_addr | output | 32 | Linear address, zero on fault |
| flt | output | 1 | Limit or privilege fault for this beat |
| cpl | output | 2 | Ring of the caller for this beat |

## Verification
Every result of a beat (address, fault flag and ring) is due on the first rising edge after the input beat is accepted. That is exactly one register stage. The stimulus is applied on the falling edge, held across one rising edge, and the outputs are read on the following falling edge. Reads therefore never coincide with the edge that updates them. In the back-pressure checks, the outputs are read again on several later falling edges while the consumer stalls. After the consumer releases, the replacing beat is read one edge after it is taken.

// File: rtl/seg_pkg.sv
`timescale 1ns/1ps
package seg_pkg;
  localparam int unsigned SEG_ADDR_W  = 32;
  localparam int unsigned SEG_LIMIT_W = 20;
  localparam int unsigned SEG_SCALE_SH = 12;
  localparam int unsigned SEG_SEL_W   = 16;
  localparam int unsigned SEG_RING_W  = 2;
endpackage

// File: rtl/seg_limit_chk.sv
`timescale 1ns/1ps
module seg_limit_chk #(
  parameter int unsigned ADDR_W   = seg_pkg::SEG_ADDR_W,
  parameter int unsigned LIMIT_W  = seg_pkg::SEG_LIMIT_W,
  parameter int unsigned SCALE_SH = seg_pkg::SEG_SCALE_SH
) (
  input  logic [ADDR_W-1:0]  off,
  input  logic [LIMIT_W-1:0] limit,
  input  logic               gran,
  output logic               over
);
  localparam int unsigned BND_W = LIMIT_W + SCALE_SH;
  localparam int unsigned CMP_W = (ADDR_W > BND_W) ? ADDR_W : BND_W;

  logic [BND_W-1:0] scaled;
  logic [CMP_W-1:0] bound;
  logic [CMP_W-1:0] off_x;

  always_comb begin
    scaled = {limit, {SCALE_SH{1'b0}}};
    off_x  = CMP_W'(off);
    bound  = gran ? CMP_W'(scaled) : CMP_W'(limit);
    over   = !(off_x < bound);
  end
endmodule

// File: rtl/seg_priv_chk.sv
`timescale 1ns/1ps
module seg_priv_chk #(
  parameter int unsigned RING_W = seg_pkg::SEG_RING_W
) (
  input  logic [RING_W-1:0] caller_ring,
  input  logic [RING_W-1:0] need_ring,
  output logic              deny
);
  assign deny = caller_ring > need_ring;
endmodule

// File: rtl/seg_out_reg.sv
`timescale 1ns/1ps
module seg_out_reg #(
  parameter int unsigned ADDR_W = seg_pkg::SEG_ADDR_W,
  parameter int unsigned RING_W = seg_pkg::SEG_RING_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              out_ready,
  input  logic [ADDR_W-1:0] nxt_addr,
  input  logic              nxt_flt,
  input  logic [RING_W-1:0] nxt_ring,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_flt,
  output logic [RING_W-1:0] out_ring
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_flt   <= 1'b0;
      out_ring  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_addr  <= nxt_addr;
      out_flt   <= nxt_flt;
      out_ring  <= nxt_ring;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_flt   <= 1'b0;
    end
  end

  // R7: a stalled beat stays frozen
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_flt) && $stable(out_ring)));

  // R9: fault flag only rides on a valid beat
  a_r9_flt_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_flt |-> out_valid);
endmodule

// File: rtl/seg_xlate.sv
`timescale 1ns/1ps
module seg_xlate #(
  parameter int unsigned ADDR_W   = seg_pkg::SEG_ADDR_W,
  parameter int unsigned LIMIT_W  = seg_pkg::SEG_LIMIT_W,
  parameter int unsigned SCALE_SH = seg_pkg::SEG_SCALE_SH,
  parameter int unsigned SEL_W    = seg_pkg::SEG_SEL_W,
  parameter int unsigned RING_W   = seg_pkg::SEG_RING_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ADDR_W-1:0]  in_off,
  input  logic [ADDR_W-1:0]  in_base,
  input  logic [LIMIT_W-1:0] in_limit,
  input  logic               in_gran,
  input  logic [SEL_W-1:0]   in_sel,
  input  logic [RING_W-1:0]  in_dpl,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  lin_addr,
  output logic               flt,
  output logic [RING_W-1:0]  cpl
);
  logic              take;
  logic              lim_over;
  logic              priv_deny;
  logic              any_flt;
  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] nxt_addr;
  logic [RING_W-1:0] ring;
  logic              unused_sel_hi;

  assign ring          = in_sel[RING_W-1:0];
  assign unused_sel_hi = ^in_sel[SEL_W-1:RING_W];

  seg_limit_chk #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .SCALE_SH(SCALE_SH)) u_lim (
    .off(in_off), .limit(in_limit), .gran(in_gran), .over(lim_over)
  );

  seg_priv_chk #(.RING_W(RING_W)) u_priv (
    .caller_ring(ring), .need_ring(in_dpl), .deny(priv_deny)
  );

  always_comb begin
    in_ready = !out_valid || out_ready;
    take     = in_valid && in_ready;
    sum      = in_base + in_off;
    any_flt  = lim_over || priv_deny;
    nxt_addr = any_flt ? '0 : sum;
  end

  seg_out_reg #(.ADDR_W(ADDR_W), .RING_W(RING_W)) u_out (
    .clk(clk), .rst_n(rst_n), .take(take), .out_ready(out_ready),
    .nxt_addr(nxt_addr), .nxt_flt(any_flt), .nxt_ring(ring),
    .out_valid(out_valid), .out_addr(lin_addr), .out_flt(flt), .out_ring(cpl)
  );

  // R1: legal beat yields base plus offset one cycle later
  a_r1_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !lim_over && !priv_deny) |=> (out_valid && !flt && lin_addr == $past(in_base + in_off)));

  // R4: ring of the caller follows the accepted beat
  a_r4_ring: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cpl == $past(in_sel[RING_W-1:0])));

  // R5: a less privileged caller is always rejected
  a_r5_priv: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (in_sel[RING_W-1:0] > in_dpl)) |=> flt);

  // R6: a faulting beat carries no address
  a_r6_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    flt |-> (lin_addr == '0));
endmodule

// File: tb/seg_xlate_test.sv
`timescale 1ns/1ps
module seg_xlate_test;
  typedef struct packed {
    logic [31:0] off;
    logic [31:0] base;
    logic [19:0] lim;
    logic        gran;
    logic [15:0] sel;
    logic [1:0]  dpl;
    logic [31:0] e_addr;
    logic        e_flt;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{32'h0000_0338, 32'h0001_0000, 20'h00FFF, 1'b0, 16'h0008, 2'd0, 32'h0001_0338, 1'b0}, // R1 R2
    '{32'h0000_0FFF, 32'h0000_0000, 20'h00FFF, 1'b0, 16'h0008, 2'd0, 32'h0000_0000, 1'b1}, // R2 edge
    '{32'h0000_0FFE, 32'h0000_1000, 20'h00FFF, 1'b0, 16'h0008, 2'd0, 32'h0000_1FFE, 1'b0}, // R2
    '{32'h00FF_FFFF, 32'h1000_0000, 20'h01000, 1'b1, 16'h0008, 2'd0, 32'h10FF_FFFF, 1'b0}, // R3
    '{32'h0100_0000, 32'h1000_0000, 20'h01000, 1'b1, 16'h0008, 2'd0, 32'h0000_0000, 1'b1}, // R3 edge
    '{32'hFFFF_EFFF, 32'h0000_2000, 20'hFFFFF, 1'b1, 16'h0008, 2'd0, 32'h0000_0FFF, 1'b0}, // R1 wrap
    '{32'h0000_0010, 32'h0000_0100, 20'h00100, 1'b0, 16'h001B, 2'd0, 32'h0000_0000, 1'b1}, // R5 deny
    '{32'h0000_0010, 32'h0000_0100, 20'h00100, 1'b0, 16'h0013, 2'd3, 32'h0000_0110, 1'b0}, // R5 equal
    '{32'h0000_0010, 32'h0000_0100, 20'h00100, 1'b0, 16'h0001, 2'd2, 32'h0000_0110, 1'b0}, // R5 more priv
    '{32'h0000_0000, 32'h0000_5000, 20'h00000, 1'b0, 16'h0008, 2'd0, 32'h0000_0000, 1'b1}  // R2 zero limit
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_off = '0;
  logic [31:0] in_base = '0;
  logic [19:0] in_limit = '0;
  logic        in_gran = 1'b0;
  logic [15:0] in_sel = '0;
  logic [1:0]  in_dpl = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] lin_addr;
  logic        flt;
  logic [1:0]  cpl;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  seg_xlate uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_off(in_off), .in_base(in_base), .in_limit(in_limit), .in_gran(in_gran),
    .in_sel(in_sel), .in_dpl(in_dpl), .out_valid(out_valid), .out_ready(out_ready),
    .lin_addr(lin_addr), .flt(flt), .cpl(cpl)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input vec_t v);
    in_off = v.off; in_base = v.base; in_limit = v.lim;
    in_gran = v.gran; in_sel = v.sel; in_dpl = v.dpl;
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R8 flt", {31'd0, flt}, 32'd0);
    chk("R8 lin_addr", lin_addr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 in_ready", {31'd0, in_ready}, 32'd1);

    // table walk: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      load(TBL[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R1 out_valid", {31'd0, out_valid}, 32'd1);
      chk("R1/R6 lin_addr", lin_addr, TBL[i].e_addr);
      chk("R2/R3/R5 flt", {31'd0, flt}, {31'd0, TBL[i].e_flt});
      chk("R4 cpl", {30'd0, cpl}, {30'd0, TBL[i].sel[1:0]});
    end

    // R9: faulting beat drained, flag drops
    @(negedge clk);
    chk("R9 out_valid idle", {31'd0, out_valid}, 32'd0);
    chk("R9 flt idle", {31'd0, flt}, 32'd0);

    // R7: back-pressure with a faulting beat held
    out_ready = 1'b0;
    load(TBL[6]);
    in_valid = 1'b1;
    @(negedge clk);
    load(TBL[0]);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 in_ready low", {31'd0, in_ready}, 32'd0);
      chk("R7 held valid", {31'd0, out_valid}, 32'd1);
      chk("R7 held flt", {31'd0, flt}, 32'd1);
      chk("R7 held addr", lin_addr, 32'd0);
      chk("R7 held cpl", {30'd0, cpl}, 32'd3);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 replaced addr", lin_addr, TBL[0].e_addr);
    chk("R7 replaced flt", {31'd0, flt}, 32'd0);
    chk("R7 replaced cpl", {30'd0, cpl}, 32'd0);
    @(negedge clk);
    chk("R7 drained", {31'd0, out_valid}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule